// File: doc/BRIEF.md
# Vector FP Exception Trap Encoder

This block sits beside the lanes of a vector floating-point unit and turns their per-element IEEE exception flags into one decision for the whole instruction. When an operation starts, it captures the element format, a single-element mode bit, the five trap-enable bits and an inexact-suppress control. It then takes one element's flags per cycle over a valid/ready handshake, in element order, starting at element 0.

The scan ends at the first element whose flags hit an enabled trap, or after the last element of the format. In single-element mode it ends after element 0. When the scan ends, the block raises `done_o` for exactly one cycle. In that cycle it presents five outputs: a trap indication, an 8-bit interrupt code built from the trapping element's index and a priority-encoded cause, the result-writeback enable, the status-register write enable, and the OR of all flags seen so far. On a trap, both the result writeback and the status update are withheld.

Top module: `vfx_trap_unit`

## Requirements
- R1: After a synchronous reset, `lane_ready_o`, `done_o`, `trap_o`, `wr_en_o` and `flag_wr_o` are low, and `vic_o` and `flag_or_o` are zero.
- R2: The element count is set by `fmt_i`: 0 gives 4 elements, 1 gives 2, and 2 or 3 give 1. With no trap, `done_o` goes high for one cycle, in the cycle after the last element's handshake.
- R3: The flag bits are ordered bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow and bit 0 inexact. `trap_en_i` uses the same order, and an element traps only if its flags AND the enables is nonzero.
- R4: The cause code is 1 for invalid, 2 for divide-by-zero, 3 for overflow, 4 for underflow and 5 for inexact. When several enabled conditions hit in one element, the lowest code wins.
- R5: On a trap, `vic_o` equals the element index times 16 plus the cause code. Without a trap, `vic_o` is 0.
- R6: With `xsup_i` set, an enabled inexact flag never causes a trap, but the other enabled conditions still trap.
- R7: The scan stops at the first trapping element. No further handshake is accepted, and `done_o` follows in the next cycle.
- R8: When `trap_o` is high, `wr_en_o` and `flag_wr_o` are low.
- R9: Without a trap, `wr_en_o` is high, `flag_or_o` is the OR of the flags of every processed element, and `flag_wr_o` is high only if that OR is nonzero.
- R10: On a trap, `flag_or_o` still reports the OR of the flags of every element up to and including the trapping one.
- R11: `lane_ready_o` is high only while scanning. A cycle without `lane_valid_i` does not advance the scan. Outside the `done_o` cycle, every result output is zero.
- R12: With `single_i` set, the scan ends after element 0 whatever the format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| fmt_i | input | 2 | Element format: 0 = 32-bit, 1 = 64-bit, 2/3 = 128-bit |
| single_i | input | 1 | Single-element mode |
| xsup_i | input | 1 | Inexact never traps |
| trap_en_i | input | 5 | Trap enables, same bit order as the flags |
| lane_valid_i | input | 1 | Current element's flags are valid |
| lane_flags_i | input | 5 | Current element's exception flags |
| lane_ready_o | output | 1 | Block accepts element flags |
| done_o | output | 1 | One-cycle completion pulse; result outputs valid |
| trap_o | output | 1 | Operation traps |
| vic_o | output | 8 | Element index in bits 7:4, cause in bits 3:0 |
| wr_en_o | output | 1 | Destination write allowed |
| flag_wr_o | output | 1 | Status flags should be ORed in |
| flag_or_o | output | 5 | Accumulated flags of processed elements |

## Verification
The bench targets the following corner cases:

- Elements carrying several enabled flags at once. A wrong priority encoder would report the wrong cause nibble.
- A trap in a later element, preceded by non-trapping flags. A design that kept scanning would take extra handshakes. One that cleared the accumulator on a trap would drop the earlier flags from `flag_or_o`.
- An enabled inexact flag under the suppress control, alone and combined with overflow. A design that masked too much or too little would trap wrongly or miss the overflow.
- Single-element mode, format code 3 and idle bubbles between handshakes. A miscounting sequencer would finish early or hang.

// File: rtl/vfx_pkg.sv
package vfx_pkg;
  localparam int NFLAG  = 5;
  localparam int CODE_W = 4;
  localparam int IDX_F  = 4;
  localparam int VIC_W  = IDX_F + CODE_W;

  // flag bit positions; cause code of bit i is NFLAG - i
  localparam int FB_INV = 4;
  localparam int FB_DVZ = 3;
  localparam int FB_OVF = 2;
  localparam int FB_UNF = 1;
  localparam int FB_INX = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } st_e;
endpackage

// File: rtl/vfx_cause_enc.sv
module vfx_cause_enc
  import vfx_pkg::*;
#(
  parameter int NF = NFLAG,
  parameter int CW = CODE_W
) (
  input  logic [NF-1:0] flags_i,
  input  logic [NF-1:0] en_i,
  input  logic          xsup_i,
  output logic          hit_o,
  output logic [CW-1:0] cause_o
);
  logic [NF-1:0] mask;
  logic [NF-1:0] hits;

  always_comb begin
    mask = en_i;
    if (xsup_i) mask[FB_INX] = 1'b0;
    hits = flags_i & mask;
    cause_o = '0;
    // higher bit overrides lower: invalid ends with the smallest code
    for (int i = 0; i < NF; i++) begin
      if (hits[i]) cause_o = CW'(NF - i);
    end
    hit_o = |hits;
  end
endmodule

// File: rtl/vfx_lane_seq.sv
module vfx_lane_seq
  import vfx_pkg::*;
#(
  parameter int MAX_LANES = 4,
  parameter int IDX_W     = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       fmt_i,
  input  logic             single_i,
  input  logic             fire_i,
  input  logic             stop_i,
  output logic             idle_o,
  output logic             scan_o,
  output logic             finish_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int CNT_W = IDX_W + 1;

  st_e              state;
  logic [CNT_W-1:0] lanes;
  logic             last;

  always_comb begin
    lanes = CNT_W'(MAX_LANES >> fmt_i);
    if (lanes == '0) lanes = CNT_W'(1);
  end

  assign last     = single_i || ({1'b0, idx_o} == lanes - CNT_W'(1));
  assign idle_o   = (state == ST_IDLE);
  assign scan_o   = (state == ST_SCAN);
  assign finish_o = scan_o && fire_i && (stop_i || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx_o <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          state <= ST_SCAN;
          idx_o <= '0;
        end
        ST_SCAN: begin
          if (finish_o)    state <= ST_DONE;
          else if (fire_i) idx_o <= idx_o + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vfx_trap_unit.sv
module vfx_trap_unit
  import vfx_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       fmt_i,
  input  logic             single_i,
  input  logic             xsup_i,
  input  logic [NFLAG-1:0] trap_en_i,
  input  logic             lane_valid_i,
  input  logic [NFLAG-1:0] lane_flags_i,
  output logic             lane_ready_o,
  output logic             done_o,
  output logic             trap_o,
  output logic [VIC_W-1:0] vic_o,
  output logic             wr_en_o,
  output logic             flag_wr_o,
  output logic [NFLAG-1:0] flag_or_o
);
  localparam int IDX_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;

  logic [1:0]       cfg_fmt;
  logic             cfg_single;
  logic             cfg_xsup;
  logic [NFLAG-1:0] cfg_en;
  logic [NFLAG-1:0] acc;
  logic [NFLAG-1:0] acc_nx;
  logic             idle;
  logic             scan;
  logic             fire;
  logic             finish;
  logic             hit;
  logic [CODE_W-1:0] cause;
  logic [IDX_W-1:0]  idx;

  assign fire         = lane_valid_i && scan;
  assign lane_ready_o = scan;
  assign acc_nx       = acc | lane_flags_i;

  vfx_cause_enc #(.NF(NFLAG), .CW(CODE_W)) u_enc (
    .flags_i (lane_flags_i),
    .en_i    (cfg_en),
    .xsup_i  (cfg_xsup),
    .hit_o   (hit),
    .cause_o (cause)
  );

  vfx_lane_seq #(.MAX_LANES(MAX_LANES), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .fmt_i    (cfg_fmt),
    .single_i (cfg_single),
    .fire_i   (fire),
    .stop_i   (hit),
    .idle_o   (idle),
    .scan_o   (scan),
    .finish_o (finish),
    .idx_o    (idx)
  );

  // configuration capture and flag accumulation
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_fmt    <= '0;
      cfg_single <= 1'b0;
      cfg_xsup   <= 1'b0;
      cfg_en     <= '0;
      acc        <= '0;
    end else if (idle && start_i) begin
      cfg_fmt    <= fmt_i;
      cfg_single <= single_i;
      cfg_xsup   <= xsup_i;
      cfg_en     <= trap_en_i;
      acc        <= '0;
    end else if (fire) begin
      acc <= acc_nx;
    end
  end

  // registered result, valid for the single done cycle
  always_ff @(posedge clk) begin
    if (rst || !finish) begin
      done_o    <= 1'b0;
      trap_o    <= 1'b0;
      vic_o     <= '0;
      wr_en_o   <= 1'b0;
      flag_wr_o <= 1'b0;
      flag_or_o <= '0;
    end else begin
      done_o    <= 1'b1;
      trap_o    <= hit;
      vic_o     <= hit ? {IDX_F'(idx), cause} : '0;
      wr_en_o   <= !hit;
      flag_wr_o <= !hit && (acc_nx != '0);
      flag_or_o <= acc_nx;
    end
  end
endmodule

// File: rtl/vfx_trap_unit_chk.sv
module vfx_trap_unit_chk
  import vfx_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             lane_ready_o,
  input logic             done_o,
  input logic             trap_o,
  input logic [VIC_W-1:0] vic_o,
  input logic             wr_en_o,
  input logic             flag_wr_o,
  input logic [NFLAG-1:0] flag_or_o
);
  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_cause_range_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && trap_o) |-> (vic_o[CODE_W-1:0] >= CODE_W'(1) &&
                            vic_o[CODE_W-1:0] <= CODE_W'(NFLAG)));

  p_lane_field_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && trap_o) |-> (int'(vic_o[VIC_W-1:CODE_W]) < MAX_LANES));

  p_vic_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !trap_o) |-> (vic_o == '0));

  p_trap_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (!wr_en_o && !flag_wr_o));

  p_commit_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !trap_o) |-> (wr_en_o && (flag_wr_o == (flag_or_o != '0))));

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (!trap_o && !wr_en_o && !flag_wr_o && vic_o == '0 && flag_or_o == '0));

  p_ready_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !lane_ready_o);
endmodule

bind vfx_trap_unit vfx_trap_unit_chk #(.MAX_LANES(MAX_LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lane_ready_o (lane_ready_o),
  .done_o       (done_o),
  .trap_o       (trap_o),
  .vic_o        (vic_o),
  .wr_en_o      (wr_en_o),
  .flag_wr_o    (flag_wr_o),
  .flag_or_o    (flag_or_o)
);

// File: tb/vfx_trap_unit_bench.sv
module vfx_trap_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] fmt_i = '0;
  logic       single_i = 1'b0;
  logic       xsup_i = 1'b0;
  logic [4:0] trap_en_i = '0;
  logic       lane_valid_i = 1'b0;
  logic [4:0] lane_flags_i = '0;
  logic       lane_ready_o, done_o, trap_o, wr_en_o, flag_wr_o;
  logic [7:0] vic_o;
  logic [4:0] flag_or_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vfx_trap_unit u_vfx_trap_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .fmt_i(fmt_i),
    .single_i(single_i), .xsup_i(xsup_i), .trap_en_i(trap_en_i),
    .lane_valid_i(lane_valid_i), .lane_flags_i(lane_flags_i),
    .lane_ready_o(lane_ready_o), .done_o(done_o), .trap_o(trap_o),
    .vic_o(vic_o), .wr_en_o(wr_en_o), .flag_wr_o(flag_wr_o),
    .flag_or_o(flag_or_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] cause_of(input logic [4:0] h);
    if (h[4])      return 4'd1;
    else if (h[3]) return 4'd2;
    else if (h[2]) return 4'd3;
    else if (h[1]) return 4'd4;
    else if (h[0]) return 4'd5;
    return 4'd0;
  endfunction

  task automatic run_op(input logic [1:0] fmt, input bit single,
                        input logic [4:0] en, input bit xsup,
                        input logic [4:0] f0, input logic [4:0] f1,
                        input logic [4:0] f2, input logic [4:0] f3,
                        input bit bubbles, input string tag);
    logic [4:0] fl [4];
    logic [4:0] acc, h;
    int nl, exp_n, got_n;
    bit exp_trap, got;
    logic [7:0] exp_vic;
    fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
    nl = single ? 1 : (fmt == 2'd0 ? 4 : (fmt == 2'd1 ? 2 : 1));
    exp_n = nl; exp_trap = 0; exp_vic = 8'h00; acc = '0;
    for (int i = 0; i < nl; i++) begin
      acc = acc | fl[i];
      h = fl[i] & en & (xsup ? 5'b11110 : 5'b11111);
      if (h != 5'b0) begin
        exp_trap = 1; exp_vic = {4'(i), cause_of(h)}; exp_n = i + 1;
        break;
      end
    end

    @(negedge clk);
    start_i = 1'b1; fmt_i = fmt; single_i = single; trap_en_i = en; xsup_i = xsup;
    @(negedge clk);
    start_i = 1'b0;
    got = 0; got_n = 0;
    for (int k = 0; k < 24 && !got; k++) begin
      if (bubbles && ($urandom % 3 == 0)) begin
        lane_valid_i = 1'b0;
        @(negedge clk);
        if (done_o) got = 1;
      end else begin
        lane_valid_i = 1'b1;
        lane_flags_i = fl[got_n % 4];
        @(negedge clk);
        got_n++;
        if (done_o) got = 1;
      end
    end
    lane_valid_i = 1'b0;
    lane_flags_i = '0;
    chk({"R2/R7/R12 ", tag}, "handshakes", got_n, exp_n);
    chk({"R3/R6 ", tag}, "trap_o", trap_o, exp_trap);
    chk({"R4/R5 ", tag}, "vic_o", vic_o, exp_vic);
    chk({"R8/R9 ", tag}, "wr_en_o", wr_en_o, !exp_trap);
    chk({"R8/R9 ", tag}, "flag_wr_o", flag_wr_o, !exp_trap && acc != 5'b0);
    chk({"R9/R10 ", tag}, "flag_or_o", flag_or_o, acc);
    chk({"R11 ", tag}, "ready in done", lane_ready_o, 1'b0);
    @(negedge clk);
    chk({"R2/R11 ", tag}, "done pulse end", {done_o, trap_o, vic_o, flag_or_o}, '0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "reset outputs",
        {lane_ready_o, done_o, trap_o, wr_en_o, flag_wr_o, vic_o, flag_or_o}, '0);

    run_op(2'd0, 0, 5'h00, 0, 5'h01, 5'h02, 5'h04, 5'h10, 0, "R9 no-enable accumulate");
    run_op(2'd0, 0, 5'h1f, 0, 5'h1f, 5'h00, 5'h00, 5'h00, 0, "R4 all flags invalid first");
    run_op(2'd0, 0, 5'h1f, 0, 5'h0c, 5'h00, 5'h00, 5'h00, 0, "R4 divzero over overflow");
    run_op(2'd1, 0, 5'h01, 1, 5'h01, 5'h01, 5'h00, 5'h00, 0, "R6 inexact suppressed");
    run_op(2'd1, 0, 5'h01, 0, 5'h01, 5'h01, 5'h00, 5'h00, 0, "R6 inexact traps");
    run_op(2'd1, 0, 5'h05, 1, 5'h00, 5'h05, 5'h00, 5'h00, 0, "R6 overflow still traps");
    run_op(2'd0, 0, 5'h02, 0, 5'h10, 5'h04, 5'h02, 5'h08, 0, "R7 R10 trap lane2");
    run_op(2'd0, 1, 5'h00, 0, 5'h04, 5'h08, 5'h10, 5'h01, 0, "R12 single element");
    run_op(2'd2, 0, 5'h00, 0, 5'h08, 5'h10, 5'h00, 5'h00, 0, "R2 fmt2 one lane");
    run_op(2'd3, 0, 5'h00, 0, 5'h00, 5'h10, 5'h00, 5'h00, 0, "R2 fmt3 one lane");
    run_op(2'd0, 0, 5'h10, 0, 5'h01, 5'h02, 5'h04, 5'h10, 1, "R5 R11 trap lane3 bubbles");
    run_op(2'd0, 0, 5'h1f, 0, 5'h00, 5'h00, 5'h00, 5'h00, 1, "R9 clean no flags");

    for (int n = 0; n < 400; n++) begin
      logic [4:0] r [4];
      for (int j = 0; j < 4; j++) r[j] = 5'($urandom & $urandom & $urandom);
      run_op(2'($urandom), ($urandom % 4) == 0, 5'($urandom & $urandom), 1'($urandom),
             r[0], r[1], r[2], r[3], 1'($urandom), "random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule